// File: doc/BRIEF.md
# B2 Signal Fail Burst Detector

This block sits behind a SONET line overhead receiver and turns per-frame B2 parity error counts into a Signal Fail (SF) alarm. On every frame strobe it takes that frame's error count and adds it to two running totals. Each total covers a sliding window of recent frames, and the window length is a programmable number of frame periods. One window is used to decide when to raise the alarm and the other is used to decide when to drop it. Both decisions compare their total against one shared 16-bit threshold.

A small byte-wide register port holds the configuration. The threshold is written as two separate bytes. The other two registers hold the declaration interval and the clear interval. Any write empties both windows so that accumulation starts again under the new settings, but the current alarm state is kept. The outputs are the SF level and a one-cycle pulse on every change of that level.

Top module: `b2_sf_burst_det`

## Requirements
- R1: After reset, `sf` and `sf_chg` are 0. The threshold reads back as 0xFFFF (0xFF at address 0 and 0xFF at address 1). Both interval registers read back as 8 (addresses 2 and 3).
- R2: The register addresses are: 0 for threshold bits 15:8, 1 for threshold bits 7:0, 2 for the declaration interval and 3 for the clear interval. A write happens at the clock edge where `cfg_wr` is high. `cfg_rdata` always shows the stored byte at `cfg_raddr`, combinationally.
- R3: A window of length L sums the error counts of the last L accepted frames, including the frame being accepted. If fewer than L frames have been accepted since the last flush, it sums all of them. A stored interval of 0 gives L = 1, and a stored interval above MAX_WIN gives L = MAX_WIN.
- R4: Suppose `sf` is 0 and a frame is accepted. If the declaration-window total including that frame is greater than the threshold, `sf` reads 1 after that clock edge.
- R5: Suppose `sf` is 1 and a frame is accepted. Let Lc be the clear-window length. `sf` reads 0 after that edge only if all of the following hold: the clear-window total is below the threshold, at least Lc frames have been accepted since the frame that declared SF, and at least Lc frames have been accepted since the last flush. Otherwise `sf` stays 1.
- R6: A window total exactly equal to the threshold neither declares nor clears SF.
- R7: `sf_chg` is high for exactly the one cycle that follows each edge at which `sf` changes, and it is low at all other times.
- R8: A register write empties both windows and restarts accumulation, and it leaves `sf` unchanged. A frame strobe in the same cycle as a write is dropped: it is not counted and it changes nothing.
- R9: With the default threshold of 0xFFFF, SF is never declared.
- R10: `sf` changes only at clock edges where a frame is accepted, which means `frame_stb` is high and `cfg_wr` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle strobe, one per received frame |
| b2_err | input | ERR_W | B2 error count of the frame, sampled with `frame_stb` |
| cfg_wr | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register write address |
| cfg_wdata | input | 8 | Register write data |
| cfg_raddr | input | 2 | Register read address |
| cfg_rdata | output | 8 | Register read data |
| sf | output | 1 | Signal Fail status |
| sf_chg | output | 1 | One-cycle pulse after each change of `sf` |

## Verification
The assertions assume that `frame_stb` is a clean, synchronous single-cycle pulse and that each frame is strobed only once. They also assume that `cfg_wr` never stays high across frame edges in a way that hides frames the bench expects to be counted. The bench drives every input on the falling clock edge and always returns `frame_stb` low between frames. It issues writes only as single-cycle pulses, apart from one deliberate case where a strobe coincides with a write. A small depth is used so that the stimulus can fill and overflow the windows, and window totals never come near saturation. This lets the bench compute each windowed total directly from its own history of error counts.

// File: rtl/b2sf_pkg.sv
package b2sf_pkg;
  localparam int SUM_W = 16;
  localparam int SUM_MAX = (1 << SUM_W) - 1;

  // One step of the running total: add the new count, drop the evicted one, saturate.
  function automatic logic [SUM_W-1:0] sat_step(input int unsigned sum,
                                                input int unsigned add,
                                                input int unsigned sub);
    int unsigned t;
    t = sum + add;
    if (sub > t) t = 0;
    else t = t - sub;
    if (t > SUM_MAX) t = SUM_MAX;
    return t[SUM_W-1:0];
  endfunction

  // Effective window length from a stored interval byte.
  function automatic int unsigned clamp_len(input logic [7:0] v, input int unsigned maxw);
    if (v == 8'd0) return 1;
    if (int'(v) > maxw) return maxw;
    return int'(v);
  endfunction

  // Ring slot holding the entry that leaves a window of length len.
  function automatic int unsigned ring_idx(input int unsigned wptr,
                                           input int unsigned len,
                                           input int unsigned depth);
    return (wptr + depth - len) % depth;
  endfunction
endpackage

// File: rtl/b2sf_regs.sv
module b2sf_regs
  import b2sf_pkg::*;
#(
  parameter int MAX_WIN = 64,
  parameter logic [7:0] LEN_RST = 8'd8,
  localparam int CNT_W = $clog2(MAX_WIN + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr,
  input  logic [1:0]            cfg_addr,
  input  logic [7:0]            cfg_wdata,
  input  logic [1:0]            cfg_raddr,
  output logic [7:0]            cfg_rdata,
  output logic [SUM_W-1:0]      thr,
  output logic [1:0][CNT_W-1:0] win_len
);
  logic [3:0][7:0] regs_q;
  int unsigned     len_i [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q[0] <= 8'hFF;
      regs_q[1] <= 8'hFF;
      regs_q[2] <= LEN_RST;
      regs_q[3] <= LEN_RST;
    end else if (cfg_wr) begin
      regs_q[cfg_addr] <= cfg_wdata;
    end
  end

  assign cfg_rdata = regs_q[cfg_raddr];
  assign thr       = {regs_q[0], regs_q[1]};

  always_comb begin
    for (int w = 0; w < 2; w++) begin
      len_i[w]   = clamp_len(regs_q[2+w], MAX_WIN);
      win_len[w] = len_i[w][CNT_W-1:0];
    end
  end
endmodule

// File: rtl/b2sf_ring.sv
module b2sf_ring
  import b2sf_pkg::*;
#(
  parameter int MAX_WIN = 64,
  parameter int ERR_W   = 8,
  localparam int CNT_W  = $clog2(MAX_WIN + 1),
  localparam int PTR_W  = (MAX_WIN > 1) ? $clog2(MAX_WIN) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push,
  input  logic                  flush,
  input  logic [ERR_W-1:0]      din,
  input  logic [1:0][CNT_W-1:0] rd_len,
  output logic [CNT_W-1:0]      fill,
  output logic [1:0][ERR_W-1:0] leave
);
  logic [ERR_W-1:0] mem [MAX_WIN];
  logic [PTR_W-1:0] wptr_q;
  logic [CNT_W-1:0] fill_q;
  int unsigned      idx [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      fill_q <= '0;
    end else if (flush) begin
      wptr_q <= '0;
      fill_q <= '0;
    end else if (push) begin
      wptr_q <= (int'(wptr_q) == MAX_WIN - 1) ? '0 : wptr_q + 1'b1;
      if (int'(fill_q) < MAX_WIN) fill_q <= fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wptr_q] <= din;
  end

  always_comb begin
    for (int w = 0; w < 2; w++) begin
      idx[w]   = ring_idx(int'(wptr_q), int'(rd_len[w]), MAX_WIN);
      leave[w] = mem[idx[w][PTR_W-1:0]];
    end
  end

  assign fill = fill_q;
endmodule

// File: rtl/b2sf_winsum.sv
module b2sf_winsum
  import b2sf_pkg::*;
#(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             flush,
  input  logic [ERR_W-1:0] din,
  input  logic [ERR_W-1:0] leave,
  input  logic             evict,
  output logic [SUM_W-1:0] sum_next
);
  logic [SUM_W-1:0] sum_q;

  always_comb begin
    if (push) sum_next = sat_step(int'(sum_q), int'(din), evict ? int'(leave) : 0);
    else      sum_next = sum_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sum_q <= '0;
    else if (flush) sum_q <= '0;
    else            sum_q <= sum_next;
  end
endmodule

// File: rtl/b2sf_decide.sv
module b2sf_decide
  import b2sf_pkg::*;
#(
  parameter int MAX_WIN = 64,
  localparam int CNT_W  = $clog2(MAX_WIN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [SUM_W-1:0] thr,
  input  logic [SUM_W-1:0] decl_sum,
  input  logic [SUM_W-1:0] clr_sum,
  input  logic [CNT_W-1:0] clr_len,
  input  logic [CNT_W-1:0] fill,
  output logic             clr_ok,
  output logic             declare_evt,
  output logic             clear_evt,
  output logic             sf,
  output logic             sf_chg
);
  logic [CNT_W-1:0] since_q;
  logic [CNT_W:0]   since_inc, fill_inc;
  logic             sf_q, chg_q;

  assign since_inc   = {1'b0, since_q} + 1'b1;
  assign fill_inc    = {1'b0, fill} + 1'b1;
  assign clr_ok      = (since_inc >= {1'b0, clr_len}) && (fill_inc >= {1'b0, clr_len});
  assign declare_evt = push && !sf_q && (decl_sum > thr);
  assign clear_evt   = push && sf_q && clr_ok && (clr_sum < thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sf_q    <= 1'b0;
      chg_q   <= 1'b0;
      since_q <= '0;
    end else begin
      chg_q <= declare_evt || clear_evt;
      if (declare_evt) begin
        sf_q    <= 1'b1;
        since_q <= '0;
      end else if (clear_evt) begin
        sf_q <= 1'b0;
      end else if (push && sf_q && int'(since_q) < MAX_WIN) begin
        since_q <= since_q + 1'b1;
      end
    end
  end

  assign sf     = sf_q;
  assign sf_chg = chg_q;
endmodule

// File: rtl/b2_sf_burst_det.sv
module b2_sf_burst_det
  import b2sf_pkg::*;
#(
  parameter int MAX_WIN = 64,
  parameter int ERR_W   = 8,
  localparam int CNT_W  = $clog2(MAX_WIN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_stb,
  input  logic [ERR_W-1:0] b2_err,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_addr,
  input  logic [7:0]       cfg_wdata,
  input  logic [1:0]       cfg_raddr,
  output logic [7:0]       cfg_rdata,
  output logic             sf,
  output logic             sf_chg
);
  logic                  push;
  logic [SUM_W-1:0]      thr_q;
  logic [1:0][CNT_W-1:0] win_len;
  logic [CNT_W-1:0]      fill;
  logic [1:0][ERR_W-1:0] leave;
  logic [1:0][SUM_W-1:0] sum_next;
  logic [SUM_W-1:0]      decl_next, clr_next;
  logic                  clr_ok, declare_evt, clear_evt;

  assign push = frame_stb && !cfg_wr;

  b2sf_regs #(.MAX_WIN(MAX_WIN)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .thr(thr_q), .win_len(win_len)
  );

  b2sf_ring #(.MAX_WIN(MAX_WIN), .ERR_W(ERR_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .push(push), .flush(cfg_wr), .din(b2_err),
    .rd_len(win_len), .fill(fill), .leave(leave)
  );

  // Window 0 covers the declaration interval, window 1 the clear interval.
  for (genvar w = 0; w < 2; w++) begin : g_win
    b2sf_winsum #(.ERR_W(ERR_W)) u_sum (
      .clk(clk), .rst_n(rst_n), .push(push), .flush(cfg_wr), .din(b2_err),
      .leave(leave[w]), .evict(fill >= win_len[w]), .sum_next(sum_next[w])
    );
  end

  assign decl_next = sum_next[0];
  assign clr_next  = sum_next[1];

  b2sf_decide #(.MAX_WIN(MAX_WIN)) u_dec (
    .clk(clk), .rst_n(rst_n), .push(push), .thr(thr_q),
    .decl_sum(decl_next), .clr_sum(clr_next), .clr_len(win_len[1]), .fill(fill),
    .clr_ok(clr_ok), .declare_evt(declare_evt), .clear_evt(clear_evt),
    .sf(sf), .sf_chg(sf_chg)
  );
endmodule

// File: rtl/b2sf_checker.sv
module b2sf_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_stb,
  input logic        cfg_wr,
  input logic        sf,
  input logic        sf_chg,
  input logic [15:0] thr_q,
  input logic [15:0] decl_next,
  input logic [15:0] clr_next,
  input logic        clr_ok
);
  // R7: every change of sf is flagged by sf_chg in the following cycle
  a_r7_chg_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (sf != $past(sf)) |-> sf_chg);
  // R7: sf_chg is never raised without a change
  a_r7_chg_only_change: assert property (@(posedge clk) disable iff (!rst_n)
    sf_chg |-> (sf != $past(sf)));
  // R10: sf moves only at an accepted frame
  a_r10_sf_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_stb && !cfg_wr) |=> $stable(sf));
  // R8: a write never alters sf
  a_r8_write_keeps_sf: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> $stable(sf));
  // R4 R6: a rise needs a declaration total strictly above the threshold
  a_r4_rise_above: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sf) |-> $past(decl_next > thr_q));
  // R5 R6: a fall needs an eligible clear total strictly below the threshold
  a_r5_fall_below: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sf) |-> $past((clr_next < thr_q) && clr_ok));
endmodule

bind b2_sf_burst_det b2sf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .cfg_wr(cfg_wr),
  .sf(sf), .sf_chg(sf_chg), .thr_q(thr_q), .decl_next(decl_next),
  .clr_next(clr_next), .clr_ok(clr_ok)
);

// File: tb/tb_b2_sf_burst_det.sv
module tb_b2_sf_burst_det;
  localparam int MAXW = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_stb = 1'b0;
  logic [7:0] b2_err = '0;
  logic       cfg_wr = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [1:0] cfg_raddr = '0;
  logic [7:0] cfg_rdata;
  logic       sf, sf_chg;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model state
  int h [4096];
  int n = 0;
  int m_sf = 0, m_since = 0, m_chg = 0;
  int m_thr = 16'hFFFF, m_dl = 8, m_cl = 8;

  always #4 clk = ~clk;

  b2_sf_burst_det #(.MAX_WIN(MAXW), .ERR_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .b2_err(b2_err),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata), .sf(sf), .sf_chg(sf_chg)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    if (v == 0) return 1;
    if (v > MAXW) return MAXW;
    return v;
  endfunction

  function automatic int wsum(input int len);
    int s = 0;
    int k = (len < n) ? len : n;
    for (int i = 0; i < k; i++) s += h[n-1-i];
    return (s > 65535) ? 65535 : s;
  endfunction

  task automatic model_frame(input int e);
    int d, c;
    h[n] = e; n++;
    d = wsum(m_dl); c = wsum(m_cl);
    m_chg = 0;
    if (m_sf == 0 && d > m_thr) begin
      m_sf = 1; m_since = 0; m_chg = 1;
    end else if (m_sf == 1 && m_since + 1 >= m_cl && n >= m_cl && c < m_thr) begin
      m_sf = 0; m_chg = 1;
    end else if (m_sf == 1 && m_since < MAXW) begin
      m_since++;
    end
  endtask

  task automatic frame(input int e, input string tag);
    @(negedge clk);
    frame_stb = 1'b1; b2_err = e[7:0];
    @(negedge clk);
    frame_stb = 1'b0;
    model_frame(e);
    chk({tag, " R4 R5 R10 sf"}, int'(sf), m_sf);
    chk("R7 sf_chg", int'(sf_chg), m_chg);
  endtask

  task automatic wr(input int a, input int v, input bit with_stb);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a[1:0]; cfg_wdata = v[7:0];
    frame_stb = with_stb; b2_err = 8'd200;
    @(negedge clk);
    cfg_wr = 1'b0; frame_stb = 1'b0;
    case (a)
      0: m_thr = (m_thr & 16'h00FF) | (v << 8);
      1: m_thr = (m_thr & 16'hFF00) | v;
      2: m_dl = eff(v);
      default: m_cl = eff(v);
    endcase
    n = 0;
    m_chg = 0;
    chk("R8 sf kept on write", int'(sf), m_sf);
    chk("R7 R8 no chg on write", int'(sf_chg), 0);
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    @(negedge clk);
    cfg_raddr = a[1:0];
    #1;
    chk(tag, int'(cfg_rdata), exp);
  endtask

  task automatic set_thr(input int t);
    wr(0, (t >> 8) & 255, 0);
    wr(1, t & 255, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 sf reset", int'(sf), 0);
    chk("R1 sf_chg reset", int'(sf_chg), 0);
    rd(0, 8'hFF, "R1 thr hi reset");
    rd(1, 8'hFF, "R1 thr lo reset");
    rd(2, 8, "R1 decl len reset");
    rd(3, 8, "R1 clr len reset");

    // R9: default threshold never declares, even at the largest counts
    for (int f = 0; f < 20; f++) frame(255, "R9");

    // R2: register map readback
    wr(0, 8'h12, 0); wr(1, 8'h34, 0); wr(2, 8'h05, 0); wr(3, 8'h07, 0);
    rd(0, 8'h12, "R2 addr0");
    rd(1, 8'h34, "R2 addr1");
    rd(2, 8'h05, "R2 addr2");
    rd(3, 8'h07, "R2 addr3");

    // R6: equality neither declares nor clears
    set_thr(10); wr(2, 1, 0); wr(3, 1, 0);
    frame(10, "R6 equal no declare");
    chk("R6 stays clear", int'(sf), 0);
    frame(11, "R4 above declares");
    chk("R4 declared", int'(sf), 1);
    frame(10, "R6 equal no clear");
    chk("R6 stays set", int'(sf), 1);
    frame(9, "R5 below clears");
    chk("R5 cleared", int'(sf), 0);

    // R3 R4 R5: sweep of window lengths and thresholds with burst patterns
    for (int di = 0; di < 3; di++) begin
      for (int ci = 0; ci < 3; ci++) begin
        for (int ti = 0; ti < 2; ti++) begin
          int dl = (di == 0) ? 1 : (di == 1) ? 3 : 8;
          int cl = (ci == 0) ? 1 : (ci == 1) ? 4 : 8;
          int th = (ti == 0) ? 12 : 30;
          set_thr(th); wr(2, dl, 0); wr(3, cl, 0);
          for (int f = 0; f < 48; f++) begin
            int e;
            if ((f % 24) < 10) e = ((f * 5 + dl + ci) % 9) + 3;
            else e = (f + ti) % 3;
            frame(e, "R3 sweep");
          end
        end
      end
    end

    // R3: clamping of stored intervals 0 and above MAX_WIN
    set_thr(20); wr(2, 0, 0); wr(3, 200, 0);
    rd(3, 200, "R2 raw readback");
    for (int f = 0; f < 40; f++) frame((f % 13 < 4) ? 21 + (f % 3) : f % 4, "R3 clamp");

    // R8: flush while set keeps sf, restarts window; coincident strobe dropped
    set_thr(15); wr(2, 2, 0); wr(3, 4, 0);
    frame(20, "R8 pre");
    chk("R8 set before flush", int'(sf), 1);
    wr(3, 4, 1);
    chk("R8 strobe with write dropped", int'(sf), 1);
    for (int f = 0; f < 6; f++) frame(1, "R8 after flush");
    frame(16, "R8 redeclare");
    for (int f = 0; f < 6; f++) frame(0, "R8 clear tail");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule